// File: doc/BRIEF.md
# Capability-Relative Data Address Checker

This block converts a 64-bit data offset into a checked virtual address using a default data capability. The capability has a valid tag, a sealed flag, load and store permission bits, a cursor, a lower bound (base) and an exclusive upper bound (top). The block adds the offset to the cursor and works out which bytes the access actually touches. It then checks those bytes against the bounds and reports the single highest-priority fault. Every fault names capability register 0.

Aligned accesses are 1, 2, 4 or 8 bytes wide. Partial left/right word and doubleword accesses cover only the bytes between the address and the edge of the enclosing naturally aligned unit. The bounds test uses that exact footprint, not the whole unit. The returned address is always cursor plus offset, even when the checked footprint starts lower. The block samples its inputs on each rising clock edge and presents the result one cycle later. An instruction-fetch access kind should never be presented. If one arrives, it is reported on a separate internal-error flag.

Top module: `cap_data_addr_check`

## Requirements
- R1: A clear capability tag raises fault cause 1 (tag), whatever the other fields hold.
- R2: With the tag set, a sealed capability raises fault cause 2 (seal), overriding permission and length faults.
- R3: With the tag set and not sealed, a load (kind 0) without load permission raises cause 3. A store (kind 1) without store permission raises cause 4.
- R4: Access kind 2 (instruction fetch) sets the internal-error output. It does not test the load or store permission. Tag, seal and length checks still apply.
- R5: The returned address is (cursor + offset) mod 2^64, with the offset taken as unsigned.
- R6: Width codes 0..3 mean 1, 2, 4 and 8 bytes. Cause 5 (length) is raised when address + size > top, or when address < base.
- R7: Let w = address mod 4 and d = address mod 8. The partial widths check these byte ranges:
  - code 4: start at the address, 4−w bytes
  - code 5: start at address−w, w+1 bytes
  - code 6: start at the address, 8−d bytes
  - code 7: start at address−d, d+1 bytes
- R8: For partial widths, the returned address is the unadjusted address, never the computed footprint start.
- R9: The faulting capability register output is always 5'b00000.
- R10: The top comparison uses 65 bits. An end of exactly 2^64 passes against top = 2^64, and an end beyond it fails.
- R11: When several causes apply, only one is reported. The order is tag, then seal, then permission, then length.
- R12: With no fault, the fault flag is 0 and the cause is 0.
- R13: Results appear one clock after the inputs are sampled. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_kind | input | 2 | 0 load, 1 store, 2 instruction fetch (illegal here) |
| acc_width | input | 3 | 0..3 aligned 1/2/4/8 bytes; 4 word-left, 5 word-right, 6 double-left, 7 double-right |
| acc_offset | input | 64 | Unsigned offset added to the cursor |
| dc_tag | input | 1 | Capability valid tag |
| dc_sealed | input | 1 | Capability sealed flag |
| dc_load_ok | input | 1 | Load permission |
| dc_store_ok | input | 1 | Store permission |
| dc_cursor | input | 64 | Capability cursor |
| dc_base | input | 64 | Inclusive lower bound |
| dc_top | input | 65 | Exclusive upper bound |
| chk_vaddr | output | 64 | Formed virtual address |
| chk_fault | output | 1 | Fault raised |
| chk_cause | output | 3 | Fault cause code (0 when no fault) |
| chk_capreg | output | 5 | Faulting capability register number |
| chk_fetch_err | output | 1 | Illegal instruction-fetch kind seen |

## Verification
The clocked properties assume that every input is a settled, known value at each sampling edge. They also assume the output register has captured at least one cycle since reset, which is why each result property is gated by a one-cycle liveness flag. The bench changes inputs only on the falling edge and checks outputs one full cycle later. Its bounds always satisfy base ≤ top. It uses only the four defined access-kind codes, and kind 2 only to exercise the internal-error path.

// File: rtl/cap_data_addr_pkg.sv
// Package: shared encodings for the capability data address checker.
// Assumes: the encodings below are fixed by the port contract in the brief.
package cap_data_addr_pkg;

    // Access kind codes presented on acc_kind.
    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    // Access width codes presented on acc_width.
    typedef enum logic [2:0] {
        WID_BYTE  = 3'd0,
        WID_HALF  = 3'd1,
        WID_WORD  = 3'd2,
        WID_DWORD = 3'd3,
        WID_WLEFT = 3'd4,
        WID_WRGHT = 3'd5,
        WID_DLEFT = 3'd6,
        WID_DRGHT = 3'd7
    } acc_width_e;

    // Fault cause codes; lower nonzero value means higher priority.
    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_TAG    = 3'd1,
        CAUSE_SEAL   = 3'd2,
        CAUSE_LOAD   = 3'd3,
        CAUSE_STORE  = 3'd4,
        CAUSE_LENGTH = 3'd5
    } fault_cause_e;

    // Width of a byte-count field able to hold 1..8.
    localparam int SIZE_W = 4;

endpackage

// File: rtl/cap_addr_form.sv
// Module: forms the virtual address as cursor plus an unsigned offset.
// Assumes: wrap-around modulo 2^ADDR_W is the intended behaviour.
module cap_addr_form #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] cursor,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] vaddr
);

    // Modular sum: the carry out of the top bit is dropped.
    always_comb begin
        vaddr = cursor + offset;
    end

endmodule

// File: rtl/cap_footprint.sv
// Module: derives the start address and byte count an access touches.
// Assumes: width is one of the eight defined codes; aligned widths are
// checked from the address itself, partial widths from the bytes between
// the address and the edge of the enclosing word or doubleword.
module cap_footprint
    import cap_data_addr_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int WORD_LG  = 2,
    parameter int DWORD_LG = 3
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  acc_width_e        width,
    output logic [ADDR_W-1:0] fp_start,
    output logic [SIZE_W-1:0] fp_size
);

    localparam int WORD_BYTES  = 1 << WORD_LG;
    localparam int DWORD_BYTES = 1 << DWORD_LG;

    logic [SIZE_W-1:0] wofs;
    logic [SIZE_W-1:0] dofs;
    logic [ADDR_W-1:0] word_floor;
    logic [ADDR_W-1:0] dword_floor;

    // Offsets within the enclosing word and doubleword, and their floors.
    always_comb begin
        wofs        = SIZE_W'(vaddr[WORD_LG-1:0]);
        dofs        = SIZE_W'(vaddr[DWORD_LG-1:0]);
        word_floor  = {vaddr[ADDR_W-1:WORD_LG], {WORD_LG{1'b0}}};
        dword_floor = {vaddr[ADDR_W-1:DWORD_LG], {DWORD_LG{1'b0}}};
    end

    // Select the start and size of the touched bytes for each width code.
    always_comb begin
        fp_start = vaddr;
        fp_size  = SIZE_W'(1);
        case (width)
            WID_BYTE:  fp_size = SIZE_W'(1);
            WID_HALF:  fp_size = SIZE_W'(2);
            WID_WORD:  fp_size = SIZE_W'(WORD_BYTES);
            WID_DWORD: fp_size = SIZE_W'(DWORD_BYTES);
            WID_WLEFT: fp_size = SIZE_W'(WORD_BYTES) - wofs;
            WID_WRGHT: begin
                fp_start = word_floor;
                fp_size  = wofs + SIZE_W'(1);
            end
            WID_DLEFT: fp_size = SIZE_W'(DWORD_BYTES) - dofs;
            WID_DRGHT: begin
                fp_start = dword_floor;
                fp_size  = dofs + SIZE_W'(1);
            end
            default:   fp_size = SIZE_W'(1);
        endcase
    end

endmodule

// File: rtl/cap_perm_check.sv
// Module: tag, seal and permission checks on the default data capability.
// Assumes: only load and store kinds are legal; fetch and the reserved code
// are flagged as an internal error and skip the permission test.
module cap_perm_check
    import cap_data_addr_pkg::*;
(
    input  logic         tag,
    input  logic         sealed,
    input  logic         load_ok,
    input  logic         store_ok,
    input  acc_kind_e    kind,
    output fault_cause_e perm_cause,
    output logic         fetch_err
);

    // Flag any kind that is neither load nor store.
    always_comb begin
        fetch_err = (kind != KIND_LOAD) && (kind != KIND_STORE);
    end

    // Priority chain: tag, then seal, then the permission for the kind.
    always_comb begin
        if (!tag) begin
            perm_cause = CAUSE_TAG;
        end else if (sealed) begin
            perm_cause = CAUSE_SEAL;
        end else if (kind == KIND_LOAD && !load_ok) begin
            perm_cause = CAUSE_LOAD;
        end else if (kind == KIND_STORE && !store_ok) begin
            perm_cause = CAUSE_STORE;
        end else begin
            perm_cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/cap_bounds_check.sv
// Module: tests a byte footprint against the capability bounds.
// Assumes: top is an exclusive bound one bit wider than the address so the
// end of the footprint can reach 2^ADDR_W without wrapping.
module cap_bounds_check
    import cap_data_addr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] fp_start,
    input  logic [SIZE_W-1:0] fp_size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   top,
    output logic              out_of_bounds
);

    logic [ADDR_W:0] fp_end;

    // Exclusive end of the footprint, carried into the extra bit.
    always_comb begin
        fp_end = {1'b0, fp_start} + (ADDR_W+1)'(fp_size);
    end

    // Out of bounds if the end passes top or the start is under base.
    always_comb begin
        out_of_bounds = (fp_end > top) || (fp_start < base);
    end

endmodule

// File: rtl/cap_data_addr_check.sv
// Module: top of the capability-relative data address checker. Combines
// address formation, footprint, permission and bounds checks, picks the
// highest-priority cause, and registers the result for one cycle.
// Assumes: inputs are stable around the rising edge; reset is synchronous
// and active low; every fault reports capability register 0.
module cap_data_addr_check
    import cap_data_addr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_kind,
    input  logic [2:0]        acc_width,
    input  logic [ADDR_W-1:0] acc_offset,
    input  logic              dc_tag,
    input  logic              dc_sealed,
    input  logic              dc_load_ok,
    input  logic              dc_store_ok,
    input  logic [ADDR_W-1:0] dc_cursor,
    input  logic [ADDR_W-1:0] dc_base,
    input  logic [ADDR_W:0]   dc_top,
    output logic [ADDR_W-1:0] chk_vaddr,
    output logic              chk_fault,
    output logic [2:0]        chk_cause,
    output logic [REG_W-1:0]  chk_capreg,
    output logic              chk_fetch_err
);

    logic [ADDR_W-1:0] vaddr_c;
    logic [ADDR_W-1:0] fp_start;
    logic [SIZE_W-1:0] fp_size;
    fault_cause_e      perm_cause;
    fault_cause_e      final_cause;
    logic              fetch_err_c;
    logic              oob;

    cap_addr_form #(.ADDR_W(ADDR_W)) u_form (
        .cursor (dc_cursor),
        .offset (acc_offset),
        .vaddr  (vaddr_c)
    );

    cap_footprint #(.ADDR_W(ADDR_W)) u_fp (
        .vaddr    (vaddr_c),
        .width    (acc_width_e'(acc_width)),
        .fp_start (fp_start),
        .fp_size  (fp_size)
    );

    cap_perm_check u_perm (
        .tag        (dc_tag),
        .sealed     (dc_sealed),
        .load_ok    (dc_load_ok),
        .store_ok   (dc_store_ok),
        .kind       (acc_kind_e'(acc_kind)),
        .perm_cause (perm_cause),
        .fetch_err  (fetch_err_c)
    );

    cap_bounds_check #(.ADDR_W(ADDR_W)) u_bounds (
        .fp_start      (fp_start),
        .fp_size       (fp_size),
        .base          (dc_base),
        .top           (dc_top),
        .out_of_bounds (oob)
    );

    // Length fault only when no earlier-priority cause is present.
    always_comb begin
        if (perm_cause != CAUSE_NONE) begin
            final_cause = perm_cause;
        end else if (oob) begin
            final_cause = CAUSE_LENGTH;
        end else begin
            final_cause = CAUSE_NONE;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vaddr     <= '0;
            chk_fault     <= 1'b0;
            chk_cause     <= 3'd0;
            chk_fetch_err <= 1'b0;
        end else begin
            chk_vaddr     <= vaddr_c;
            chk_fault     <= (final_cause != CAUSE_NONE);
            chk_cause     <= final_cause;
            chk_fetch_err <= fetch_err_c;
        end
    end

    // Faults always name the default data capability, register zero.
    always_comb begin
        chk_capreg = '0;
    end

    // Liveness flag: outputs reflect sampled inputs from the previous edge.
    logic chk_live;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    AST_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && !$past(dc_tag) |-> chk_fault && chk_cause == CAUSE_TAG)
        else $error("tag fault not reported first"); // R1
    AST_SEAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && $past(dc_tag && dc_sealed) |-> chk_cause == CAUSE_SEAL)
        else $error("seal fault not reported"); // R2
    AST_FETCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && $past(acc_kind == KIND_FETCH) |-> chk_fetch_err)
        else $error("fetch kind not flagged"); // R4
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live |-> chk_vaddr == $past(dc_cursor + acc_offset))
        else $error("address not cursor plus offset"); // R5
    AST_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live && !chk_fault |-> chk_vaddr >= $past(dc_base))
        else $error("clean result below base"); // R6
    AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_fault |-> chk_cause == 3'd0)
        else $error("cause nonzero without fault"); // R12

endmodule

// File: tb/cap_data_addr_check_bench.sv
module cap_data_addr_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_width = '0;
    logic [63:0] acc_offset = '0;
    logic        dc_tag = 1'b0;
    logic        dc_sealed = 1'b0;
    logic        dc_load_ok = 1'b0;
    logic        dc_store_ok = 1'b0;
    logic [63:0] dc_cursor = '0;
    logic [63:0] dc_base = '0;
    logic [64:0] dc_top = '0;
    logic [63:0] chk_vaddr;
    logic        chk_fault;
    logic [2:0]  chk_cause;
    logic [4:0]  chk_capreg;
    logic        chk_fetch_err;

    int n_vec = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    cap_data_addr_check u_cap_data_addr_check (
        .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_width(acc_width),
        .acc_offset(acc_offset), .dc_tag(dc_tag), .dc_sealed(dc_sealed),
        .dc_load_ok(dc_load_ok), .dc_store_ok(dc_store_ok),
        .dc_cursor(dc_cursor), .dc_base(dc_base), .dc_top(dc_top),
        .chk_vaddr(chk_vaddr), .chk_fault(chk_fault), .chk_cause(chk_cause),
        .chk_capreg(chk_capreg), .chk_fetch_err(chk_fetch_err)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        tag;
        logic        sealed;
        logic        lok;
        logic        sok;
        logic [1:0]  kind;
        logic [2:0]  wid;
        logic [63:0] cursor;
        logic [63:0] offset;
        logic [63:0] base;
        logic [64:0] top;
        logic        e_fault;
        logic [2:0]  e_cause;
        logic [63:0] e_addr;
        logic        e_ferr;
    } vec_t;

    localparam logic [63:0] C0 = 64'h1000;
    localparam logic [64:0] T0 = 65'h1010;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [64:0] TMAX = 65'h1_0000_0000_0000_0000;
    localparam int NV = 25;

    localparam vec_t VECS [NV] = '{
        // R5 R12 clean byte load
        '{8'd5, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd0, C0, 64'h0,  C0, T0, 1'b0,3'd0, 64'h1000, 1'b0},
        // R1 R11 tag clear beats seal, permission and length
        '{8'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0,3'd3, C0, 64'h9,  C0, T0, 1'b1,3'd1, 64'h1009, 1'b0},
        // R2 sealed
        '{8'd2, 1'b1,1'b1,1'b0,1'b1, 2'd0,3'd0, C0, 64'h0,  C0, T0, 1'b1,3'd2, 64'h1000, 1'b0},
        // R3 load without load permission
        '{8'd3, 1'b1,1'b0,1'b0,1'b1, 2'd0,3'd2, C0, 64'h4,  C0, T0, 1'b1,3'd3, 64'h1004, 1'b0},
        // R3 store without store permission
        '{8'd3, 1'b1,1'b0,1'b1,1'b0, 2'd1,3'd2, C0, 64'h4,  C0, T0, 1'b1,3'd4, 64'h1004, 1'b0},
        // R6 store dword ending exactly at top
        '{8'd6, 1'b1,1'b0,1'b0,1'b1, 2'd1,3'd3, C0, 64'h8,  C0, T0, 1'b0,3'd0, 64'h1008, 1'b0},
        // R6 load dword one byte past top
        '{8'd6, 1'b1,1'b0,1'b1,1'b0, 2'd0,3'd3, C0, 64'h9,  C0, T0, 1'b1,3'd5, 64'h1009, 1'b0},
        // R6 half below base
        '{8'd6, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd1, C0, 64'h0,  64'h1004, T0, 1'b1,3'd5, 64'h1000, 1'b0},
        // R6 half ending at top
        '{8'd6, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd1, C0, 64'hE,  C0, T0, 1'b0,3'd0, 64'h100E, 1'b0},
        // R7 word-left w=1 touches 3 bytes, fits
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd4, C0, 64'hD,  C0, T0, 1'b0,3'd0, 64'h100D, 1'b0},
        // R7 word-left w=0 touches 4 bytes, fits
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd1,3'd4, C0, 64'hC,  C0, T0, 1'b0,3'd0, 64'h100C, 1'b0},
        // R7 word-right starts below base
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd5, C0, 64'h3,  64'h1002, T0, 1'b1,3'd5, 64'h1003, 1'b0},
        // R8 word-right returns unadjusted address
        '{8'd8, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd5, C0, 64'h3,  C0, T0, 1'b0,3'd0, 64'h1003, 1'b0},
        // R7 double-left d=7 one byte at top edge
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd6, C0, 64'hF,  C0, T0, 1'b0,3'd0, 64'h100F, 1'b0},
        // R7 double-left d=1 seven bytes, fits where aligned dword fails
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd6, C0, 64'h9,  C0, T0, 1'b0,3'd0, 64'h1009, 1'b0},
        // R7 double-right start below base
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd1,3'd7, C0, 64'hF,  64'h1009, T0, 1'b1,3'd5, 64'h100F, 1'b0},
        // R8 double-right fits, unadjusted address
        '{8'd8, 1'b1,1'b0,1'b1,1'b1, 2'd1,3'd7, C0, 64'hF,  64'h1008, T0, 1'b0,3'd0, 64'h100F, 1'b0},
        // R7 double-right d=0 at top, one byte out
        '{8'd7, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd7, C0, 64'h10, C0, T0, 1'b1,3'd5, 64'h1010, 1'b0},
        // R5 address wraps modulo 2^64
        '{8'd5, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 64'h0, 65'h20, 1'b0,3'd0, 64'h10, 1'b0},
        // R10 end exactly 2^64 passes
        '{8'd10, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd0, ONES, 64'h0, 64'h0, TMAX, 1'b0,3'd0, ONES, 1'b0},
        // R10 end beyond 2^64 fails
        '{8'd10, 1'b1,1'b0,1'b1,1'b1, 2'd0,3'd3, ONES, 64'h0, 64'h0, TMAX, 1'b1,3'd5, ONES, 1'b0},
        // R11 seal beats permission and length
        '{8'd11, 1'b1,1'b1,1'b0,1'b0, 2'd0,3'd3, C0, 64'h9, C0, T0, 1'b1,3'd2, 64'h1009, 1'b0},
        // R11 permission beats length
        '{8'd11, 1'b1,1'b0,1'b0,1'b1, 2'd0,3'd3, C0, 64'h9, C0, T0, 1'b1,3'd3, 64'h1009, 1'b0},
        // R4 fetch kind flagged, permissions not tested
        '{8'd4, 1'b1,1'b0,1'b0,1'b0, 2'd2,3'd2, C0, 64'h0, C0, T0, 1'b0,3'd0, 64'h1000, 1'b1},
        // R4 fetch kind with tag clear still reports tag fault
        '{8'd4, 1'b0,1'b0,1'b1,1'b1, 2'd2,3'd2, C0, 64'h0, C0, T0, 1'b1,3'd1, 64'h1000, 1'b1}
    };

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        acc_kind = v.kind;   acc_width = v.wid;    acc_offset = v.offset;
        dc_tag = v.tag;      dc_sealed = v.sealed;
        dc_load_ok = v.lok;  dc_store_ok = v.sok;
        dc_cursor = v.cursor; dc_base = v.base;    dc_top = v.top;
    endtask

    initial begin
        // Reset held with non-trivial inputs: outputs must read zero (R13).
        drive(VECS[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 reset vaddr", chk_vaddr, 64'h0);
        check("R13 reset fault", 64'(chk_fault), 64'h0);
        check("R13 reset cause", 64'(chk_cause), 64'h0);
        check("R13 reset fetch_err", 64'(chk_fetch_err), 64'h0);
        rst_n = 1'b1;

        // Table walk: drive on falling edge, result visible after next rising edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d vaddr", VECS[i].req, i), chk_vaddr, VECS[i].e_addr);
            check($sformatf("R%0d vec%0d fault", VECS[i].req, i), 64'(chk_fault), 64'(VECS[i].e_fault));
            check($sformatf("R%0d vec%0d cause", VECS[i].req, i), 64'(chk_cause), 64'(VECS[i].e_cause));
            check($sformatf("R%0d vec%0d fetch_err", VECS[i].req, i), 64'(chk_fetch_err), 64'(VECS[i].e_ferr));
            check($sformatf("R9 vec%0d capreg", i), 64'(chk_capreg), 64'h0);
        end

        // R13: one-cycle latency -- before the edge the old result still shows.
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        drive(VECS[6]);
        #5;
        check("R13 output held before edge", 64'(chk_fault), 64'h0);
        @(posedge clk);
        @(negedge clk);
        check("R13 output after edge", 64'(chk_cause), 64'h5);

        // R13: synchronous reset clears a faulting result.
        rst_n = 1'b0;
        #5;
        check("R13 reset is synchronous", 64'(chk_fault), 64'h1);
        @(posedge clk);
        @(negedge clk);
        check("R13 reset clears fault", 64'(chk_fault), 64'h0);
        check("R13 reset clears vaddr", chk_vaddr, 64'h0);
        rst_n = 1'b1;

        // R12: clean access after a fault returns cause to zero.
        drive(VECS[5]);
        @(posedge clk);
        @(negedge clk);
        check("R12 clean cause", 64'(chk_cause), 64'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL R13 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule